// File: doc/BRIEF.md
# Mailbox-Commanded Power Sequencer

This block is the command engine of a power-management controller. An application processor leaves a 16-bit command code in a shared 32-bit message register and then pulses a notify line. The block checks the code and picks the ordered list of power actions that belongs to it. It then runs that list one step at a time. The actions are a clock force-sleep request, an off request for the core power domain, an off request for the peripheral power domain, a strobe that programs the real-time-clock alarm, and arming of the main oscillator's disable. Each step raises one or more request lines and waits until every matching acknowledge is high.

The upper half of the message register is a status field that only the block writes. It shows "in progress" as soon as a command starts. For the deep-sleep commands it shows "wait for OK" while the block waits for the application processor's wait-for-interrupt. At the end it shows pass or fail. The step timeout is set by an input, in clock cycles. The status value stays in place until the next notify is accepted.

Top module: `pwr_cmd_seq`

## Requirements
- R1: After reset, rd_data reads 0 and act_req is 0. rd_data[15:0] is the command code and rd_data[31:16] is the status. While the block is idle, wr_en loads wr_code into bits 15:0 at the next clock edge and leaves the status bits unchanged.
- R2: A notify that is sampled while the block is idle and that carries a valid code (0x1, 0x2, 0x3 or 0x5) sets the status to 0x2 (in progress) after that edge. The request of the first step appears after the same edge.
- R3: Code 0x1 makes the requests in this order: bit 0 (clock force-sleep); then bits 1 and 2 together (core and peripheral domain off); then bit 3 (alarm strobe). It ends with status 0x1 (pass).
- R4: Code 0x2 makes one request only, bit 3 (alarm strobe), and then ends with pass.
- R5: Code 0x3 makes these requests in order: bit 0; then bits 1 and 2; then a wait for wfi_seen; then bit 4 (oscillator-disable arm). It then ends with pass.
- R6: Code 0x5 follows the order of R5, except that its domain step requests only bit 1.
- R7: When the domain step of code 0x3 or 0x5 completes, the status becomes 0x4 (wait for OK) and act_req stays 0. The bit 4 request appears only after an edge at which wfi_seen is high. The status stays 0x4 until the command ends. A request appears only while the status is 0x2 or 0x4.
- R8: A notify accepted with any other code (for example 0x0, 0x4 or 0xFFFF) sets the status to 0x3 (fail) after that edge and raises no request.
- R9: A step's request stays steady until an edge at which all of its requested acknowledges are high. Edges are counted from 0, starting at the first edge after the request appears. If that has not happened by edge tmo_lim, the status becomes 0x3 at that edge and all requests drop.
- R10: While a command runs, notify and wr_en are ignored: the code does not change and the sequence is not disturbed. After a command ends, its status is held until the next accepted notify.
- R11: After the edge at which the final step's acknowledges are sampled, the status is 0x1 and act_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the command-code half of the message register |
| wr_code | input | 16 | Command code to write |
| notify | input | 1 | Single-cycle pulse that asks the block to execute the stored code |
| rd_data | output | 32 | Message register readback: {status, code} |
| tmo_lim | input | TMO_W (8) | Last edge index allowed for a step's acknowledge |
| wfi_seen | input | 1 | The application processor has entered wait-for-interrupt |
| act_req | output | 5 | Action requests: 0 clock sleep, 1 core domain off, 2 peripheral domain off, 3 alarm strobe, 4 oscillator-disable arm |
| act_ack | input | 5 | Acknowledges, one per act_req bit |

## Verification
Suppose the sequencer's step index or its state went wrong. The recorded order of request masks would then stop matching the code's list by the very next step: an action would be skipped, repeated or made early. Bit 4 could also rise without a wfi_seen edge before it. A timer that is off by one shows up only when the acknowledge delay sits exactly at tmo_lim. There the final status flips between pass and fail one edge after the boundary acknowledge, so the bench aims delays at that limit and one past it. A bad idle decode shows up in the cycle after notify: a stray request, a missing in-progress status, or a code that changes while busy.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int CODE_W = 16;
  localparam int STAT_W = 16;
  localparam int NACT   = 5;
  localparam int NSLOT  = 5;
  localparam int IDX_W  = $clog2(NSLOT + 1);

  localparam logic [STAT_W-1:0] ST_NONE = 16'h0000;
  localparam logic [STAT_W-1:0] ST_PASS = 16'h0001;
  localparam logic [STAT_W-1:0] ST_BUSY = 16'h0002;
  localparam logic [STAT_W-1:0] ST_FAIL = 16'h0003;
  localparam logic [STAT_W-1:0] ST_WAIT = 16'h0004;

  localparam logic [CODE_W-1:0] OP_ALARM_FULL  = 16'h0001;
  localparam logic [CODE_W-1:0] OP_ALARM_QUICK = 16'h0002;
  localparam logic [CODE_W-1:0] OP_SLEEP_A     = 16'h0003;
  localparam logic [CODE_W-1:0] OP_SLEEP_B     = 16'h0005;

  localparam logic [NACT-1:0] A_CLK   = 5'b00001;
  localparam logic [NACT-1:0] A_CORE  = 5'b00010;
  localparam logic [NACT-1:0] A_PERI  = 5'b00100;
  localparam logic [NACT-1:0] A_ALARM = 5'b01000;
  localparam logic [NACT-1:0] A_OSC   = 5'b10000;

  typedef enum logic [1:0] {SK_END, SK_ACT, SK_WFI} slot_kind_e;
  typedef enum logic [1:0] {FS_IDLE, FS_EXEC, FS_WFIW} fsm_e;

  typedef struct packed {
    slot_kind_e      kind;
    logic [NACT-1:0] mask;
  } slot_t;

  function automatic logic op_valid(input logic [CODE_W-1:0] code);
    return (code == OP_ALARM_FULL) || (code == OP_ALARM_QUICK) ||
           (code == OP_SLEEP_A) || (code == OP_SLEEP_B);
  endfunction

  function automatic slot_t mk(input slot_kind_e k, input logic [NACT-1:0] m);
    slot_t s;
    s.kind = k;
    s.mask = m;
    return s;
  endfunction

  // Program of each command: one slot per step, SK_END terminates.
  function automatic slot_t op_slot(input logic [CODE_W-1:0] code,
                                    input logic [IDX_W-1:0] idx);
    slot_t s;
    s = mk(SK_END, '0);
    case (code)
      OP_ALARM_FULL: begin
        case (idx)
          3'd0:    s = mk(SK_ACT, A_CLK);
          3'd1:    s = mk(SK_ACT, A_CORE | A_PERI);
          3'd2:    s = mk(SK_ACT, A_ALARM);
          default: s = mk(SK_END, '0);
        endcase
      end
      OP_ALARM_QUICK: begin
        case (idx)
          3'd0:    s = mk(SK_ACT, A_ALARM);
          default: s = mk(SK_END, '0);
        endcase
      end
      OP_SLEEP_A, OP_SLEEP_B: begin
        case (idx)
          3'd0:    s = mk(SK_ACT, A_CLK);
          3'd1:    s = mk(SK_ACT, (code == OP_SLEEP_A) ? (A_CORE | A_PERI) : A_CORE);
          3'd2:    s = mk(SK_WFI, '0);
          3'd3:    s = mk(SK_ACT, A_OSC);
          default: s = mk(SK_END, '0);
        endcase
      end
      default: s = mk(SK_END, '0);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pcs_msg_reg.sv
module pcs_msg_reg #(
  parameter int CODE_W = 16,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_in,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_in,
  output logic [CODE_W-1:0] code_q,
  output logic [STAT_W-1:0] stat_q
);
  logic [CODE_W-1:0] code_n;
  logic [STAT_W-1:0] stat_n;

  always_comb begin
    code_n = code_we ? code_in : code_q;
    stat_n = stat_we ? stat_in : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      stat_q <= '0;
    end else begin
      code_q <= code_n;
      stat_q <= stat_n;
    end
  end
endmodule

// File: rtl/pcs_step_timer.sv
module pcs_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] lim,
  output logic         expired
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (run && (cnt_q != CNT_MAX));
    cnt_n  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign expired = (cnt_q >= lim);
endmodule

// File: rtl/pcs_seq_fsm.sv
module pcs_seq_fsm
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              notify,
  input  logic [CODE_W-1:0] code,
  input  logic              wfi_seen,
  input  logic [NACT-1:0]   ack,
  input  logic              expired,
  output logic [NACT-1:0]   req,
  output logic              idle,
  output logic              tmr_clr,
  output logic              tmr_run,
  output logic              stat_we,
  output logic [STAT_W-1:0] stat_val
);
  fsm_e              state_q, state_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [CODE_W-1:0] op_q;
  logic              op_en;
  slot_t             slot_cur, slot_nxt;
  logic              all_ack;

  always_comb begin
    slot_cur = op_slot(op_q, idx_q);
    slot_nxt = op_slot(op_q, idx_q + 1'b1);
    all_ack  = ((ack & slot_cur.mask) == slot_cur.mask);
  end

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    op_en    = 1'b0;
    tmr_clr  = 1'b0;
    stat_we  = 1'b0;
    stat_val = ST_NONE;
    case (state_q)
      FS_IDLE: begin
        if (notify) begin
          stat_we = 1'b1;
          if (op_valid(code)) begin
            op_en    = 1'b1;
            state_n  = FS_EXEC;
            idx_n    = '0;
            tmr_clr  = 1'b1;
            stat_val = ST_BUSY;
          end else begin
            stat_val = ST_FAIL;
          end
        end
      end
      FS_EXEC: begin
        if (all_ack) begin
          idx_n   = idx_q + 1'b1;
          tmr_clr = 1'b1;
          case (slot_nxt.kind)
            SK_ACT: state_n = FS_EXEC;
            SK_WFI: begin
              state_n  = FS_WFIW;
              stat_we  = 1'b1;
              stat_val = ST_WAIT;
            end
            default: begin
              state_n  = FS_IDLE;
              stat_we  = 1'b1;
              stat_val = ST_PASS;
            end
          endcase
        end else if (expired) begin
          state_n  = FS_IDLE;
          stat_we  = 1'b1;
          stat_val = ST_FAIL;
        end
      end
      FS_WFIW: begin
        if (wfi_seen) begin
          idx_n   = idx_q + 1'b1;
          state_n = FS_EXEC;
          tmr_clr = 1'b1;
        end
      end
      default: state_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= '0;
    else if (op_en) op_q <= code;
  end

  assign req     = (state_q == FS_EXEC) ? slot_cur.mask : '0;
  assign idle    = (state_q == FS_IDLE);
  assign tmr_run = (state_q == FS_EXEC);
endmodule

// File: rtl/pwr_cmd_seq.sv
module pwr_cmd_seq
  import pcs_pkg::*;
#(
  parameter int TMO_W = 8,
  localparam int MSG_W = CODE_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              notify,
  output logic [MSG_W-1:0]  rd_data,
  input  logic [TMO_W-1:0]  tmo_lim,
  input  logic              wfi_seen,
  output logic [NACT-1:0]   act_req,
  input  logic [NACT-1:0]   act_ack
);
  logic              rst_n_int;
  logic              idle, tmr_clr, tmr_run, expired, stat_we;
  logic [STAT_W-1:0] stat_val, stat_q;
  logic [CODE_W-1:0] code_q;

  pcs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  pcs_msg_reg #(.CODE_W(CODE_W), .STAT_W(STAT_W)) u_reg (
    .clk(clk), .rst_n(rst_n_int),
    .code_we(wr_en && idle), .code_in(wr_code),
    .stat_we(stat_we), .stat_in(stat_val),
    .code_q(code_q), .stat_q(stat_q)
  );

  pcs_step_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_int), .clr(tmr_clr), .run(tmr_run),
    .lim(tmo_lim), .expired(expired)
  );

  pcs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int), .notify(notify), .code(code_q),
    .wfi_seen(wfi_seen), .ack(act_ack), .expired(expired),
    .req(act_req), .idle(idle), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .stat_we(stat_we), .stat_val(stat_val)
  );

  assign rd_data = {stat_q, code_q};
endmodule

// File: rtl/pwr_cmd_seq_chk.sv
module pwr_cmd_seq_chk
  import pcs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            notify,
  input logic            wfi_seen,
  input logic [NACT-1:0] act_req,
  input logic [NACT-1:0] act_ack,
  input logic [31:0]     rd_data
);
  logic [15:0] st;
  logic        busy;
  assign st   = rd_data[31:16];
  assign busy = (st == ST_BUSY) || (st == ST_WAIT);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (notify && !busy && op_valid(rd_data[15:0])) |=> (st == ST_BUSY));

  // R8
  bad_code_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (notify && !busy && !op_valid(rd_data[15:0])) |=> (st == ST_FAIL && act_req == '0));

  // R7
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req != '0) |-> busy);

  // R7
  osc_after_wfi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_req[4]) |-> $past(wfi_seen));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req != '0 && ((act_ack & act_req) != act_req)) |=>
      ((act_req == $past(act_req)) || (st == ST_FAIL)));

  // R10
  busy_code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_data[15:0]));

  // R11
  pass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PASS) |-> (act_req == '0));
endmodule

bind pwr_cmd_seq pwr_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .notify(notify), .wfi_seen(wfi_seen),
  .act_req(act_req), .act_ack(act_ack), .rd_data(rd_data)
);

// File: tb/pwr_cmd_seq_tb_top.sv
module pwr_cmd_seq_tb_top;
  logic        clk, rst_n, wr_en, notify, wfi_seen;
  logic [15:0] wr_code;
  logic [31:0] rd_data;
  logic [7:0]  tmo_lim;
  logic [4:0]  act_req, act_ack;

  int n_chk = 0, n_fail = 0;
  int ack_dly = 0;
  int rcnt [5];
  int log_mask [8];
  int log_n = 0;
  logic [4:0] prev_req = '0;
  bit done = 0;

  pwr_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .notify(notify), .rd_data(rd_data), .tmo_lim(tmo_lim),
    .wfi_seen(wfi_seen), .act_req(act_req), .act_ack(act_ack)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // acknowledge responder: ack of bit i is high from edge ack_dly after its request rose
  always_ff @(posedge clk) begin
    for (int i = 0; i < 5; i++) rcnt[i] <= act_req[i] ? rcnt[i] + 1 : 0;
  end
  always_comb begin
    for (int i = 0; i < 5; i++) act_ack[i] = act_req[i] && (rcnt[i] >= ack_dly);
  end

  // log every new nonzero request pattern
  always @(negedge clk) begin
    if (act_req != prev_req && act_req != 0 && log_n < 8) begin
      log_mask[log_n] = int'(act_req);
      log_n++;
    end
    prev_req = act_req;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  function automatic bit is_valid(input int c);
    return c == 1 || c == 2 || c == 3 || c == 5;
  endfunction
  function automatic bit is_sleep(input int c);
    return c == 3 || c == 5;
  endfunction
  function automatic int exp_len(input int c);
    return (c == 2) ? 1 : (is_valid(c) ? 3 : 0);
  endfunction
  function automatic int exp_mask(input int c, input int i);
    case (c)
      1: return (i == 0) ? 1 : (i == 1) ? 6 : 8;
      2: return 8;
      3: return (i == 0) ? 1 : (i == 1) ? 6 : 16;
      5: return (i == 0) ? 1 : (i == 1) ? 2 : 16;
      default: return 0;
    endcase
  endfunction
  function automatic string tag_of(input int c);
    case (c)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      5: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic run_cmd(input int code, input int d, input int lim, input int wdly);
    int  st_before, n_exp, exp_st;
    bit  pass_exp, saw_wait;
    ack_dly = d;
    tmo_lim = 8'(lim);
    st_before = int'(rd_data[31:16]);
    wr_en = 1; wr_code = 16'(code);
    tick();
    wr_en = 0;
    chk(rd_data[15:0] == 16'(code), "R1", "code written", int'(rd_data[15:0]), code);
    chk(int'(rd_data[31:16]) == st_before, "R1", "status kept on write",
        int'(rd_data[31:16]), st_before);
    log_n = 0;
    notify = 1;
    tick();
    notify = 0;
    pass_exp = (d <= lim);
    saw_wait = 0;
    if (!is_valid(code)) begin
      chk(rd_data[31:16] == 16'h3, "R8", "bad code status", int'(rd_data[31:16]), 3);
      chk(act_req == 0, "R8", "bad code no request", int'(act_req), 0);
      exp_st = 3;
    end else begin
      chk(rd_data[31:16] == 16'h2, "R2", "in progress", int'(rd_data[31:16]), 2);
      chk(int'(act_req) == exp_mask(code, 0), "R2", "first request", int'(act_req),
          exp_mask(code, 0));
      // stray write and notify while busy
      wr_en = 1; wr_code = 16'h0002; notify = 1;
      tick();
      wr_en = 0; notify = 0;
      for (int k = 0; k < 200; k++) begin
        if (rd_data[31:16] == 16'h1 || rd_data[31:16] == 16'h3) break;
        if (rd_data[31:16] == 16'h4 && !saw_wait) begin
          saw_wait = 1;
          chk(act_req == 0, "R7", "quiet at wait", int'(act_req), 0);
          for (int w = 0; w < wdly; w++) begin
            tick();
            chk(act_req == 0 && rd_data[31:16] == 16'h4, "R7", "hold until wfi",
                int'({rd_data[31:16], 3'b0, act_req}), 32'h40000);
          end
          wfi_seen = 1;
          tick();
          wfi_seen = 0;
          chk(rd_data[31:16] == 16'h4, "R7", "status after wfi", int'(rd_data[31:16]), 4);
        end else begin
          tick();
        end
      end
      exp_st = pass_exp ? 1 : 3;
      chk(saw_wait == (pass_exp && is_sleep(code)), "R7", "wait-for-OK shown",
          int'(saw_wait), int'(pass_exp && is_sleep(code)));
      chk(int'(rd_data[31:16]) == exp_st, pass_exp ? "R11" : "R9", "final status",
          int'(rd_data[31:16]), exp_st);
      chk(act_req == 0, pass_exp ? "R11" : "R9", "requests dropped", int'(act_req), 0);
      n_exp = pass_exp ? exp_len(code) : 1;
      chk(log_n == n_exp, tag_of(code), "step count", log_n, n_exp);
      for (int i = 0; i < n_exp && i < log_n; i++)
        chk(log_mask[i] == exp_mask(code, i), tag_of(code), "step order",
            log_mask[i], exp_mask(code, i));
      chk(rd_data[15:0] == 16'(code), "R10", "code unchanged while busy",
          int'(rd_data[15:0]), code);
    end
    repeat (3) tick();
    chk(int'(rd_data[31:16]) == exp_st, "R10", "status held", int'(rd_data[31:16]), exp_st);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; wr_en = 0; wr_code = 0; notify = 0; wfi_seen = 0; tmo_lim = 8'd3;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    chk(rd_data == 0, "R1", "reset readback", int'(rd_data), 0);
    chk(act_req == 0, "R1", "reset requests", int'(act_req), 0);
    // directed corner cases
    run_cmd(1, 0, 3, 0);
    run_cmd(2, 2, 2, 0);   // acknowledge on the limit edge passes
    run_cmd(3, 3, 2, 0);   // one past the limit fails
    run_cmd(5, 1, 1, 2);
    run_cmd(5, 1, 0, 0);
    run_cmd(3, 0, 0, 4);
    run_cmd(0, 0, 3, 0);
    run_cmd(4, 0, 3, 0);
    run_cmd(16'hFFFF, 0, 3, 0);
    // constrained random
    for (int n = 0; n < 40; n++) begin
      int c;
      c = int'($urandom % 8);
      run_cmd(c, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule